// File: doc/BRIEF.md
# One-Time-Programmable Memory Adaptive Pulse Programmer

This block programs a run of one-time-programmable memory bytes, starting at address zero, using an adaptive pulse scheme. For each byte it puts the memory into program mode and drives the address. It latches that address with a rising strobe, presents the data byte and then issues fixed-width initial program pulses. After each pulse it reads the byte back in verify mode. Once the read-back matches, it has counted how many initial pulses the byte needed. It then applies one overprogram pulse whose width is three times that count, in units of the initial pulse width. A byte that still mismatches after the allowed number of initial pulses is marked as failed and gets no overprogram pulse.

Two digital enables wrap the run. The high-voltage mode enable rises first and falls last, and the programming-supply enable sits inside it. After the supply enable drops, a closing pass latches every byte again in verify mode and compares it with the data source. The block then raises `done` together with an overall pass flag and the address of the first failure it detected. The data source is a combinational lookup: the block drives `src_addr` and reads `src_data` back in the same cycle.

Top module: `otp_prog_seq`

## Requirements
- R1: Each initial program pulse drives `prog_n` low (active low) for exactly `PULSE_CYC` clock cycles.
- R2: Between two initial pulses of the same byte, `verify_sel` is high (verify mode) and `rd_data` is compared with the byte being written; `verify_sel` is high in the cycle after every initial pulse ends.
- R3: A byte receives at most `MAX_TRY` initial pulses. If the read-back still mismatches after the last one, the byte receives no overprogram pulse and is recorded as a failure.
- R4: When the read-back matches after X initial pulses, exactly one overprogram pulse follows, with `prog_n` low for 3·X·`PULSE_CYC` cycles.
- R5: Bytes are programmed in ascending address order from 0 to `byte_cnt`-1. Each byte is finished before the next address is latched, and `mem_addr` stays steady while `prog_n` is low.
- R6: For each byte, the block first drives the address with `verify_sel` low and `addr_latch` low. `addr_latch` then rises, and `mem_data` carries `src_data` of that address. Only after that is the first pulse issued. While `prog_n` is low, `addr_latch` is high, `verify_sel` is low and `vpp_en` is high.
- R7: `hv_en` rises at least `GAP_CYC` cycles before `vpp_en` rises and falls at least `GAP_CYC` cycles after `vpp_en` falls; `vpp_en` is never high while `hv_en` is low.
- R8: After programming, with `vpp_en` low, every byte from 0 to `byte_cnt`-1 is latched again in ascending order with `verify_sel` high, and `rd_data` is compared with `src_data`. No pulse is issued in this pass.
- R9: At the end of the run, `done` rises and stays high until the next `start`, and `busy` and `hv_en` are low. `pass` is 1 only if no byte failed in either pass. `fail_addr` holds the address of the first failure in detection order, or 0 when `pass` is 1.
- R10: A run with `byte_cnt` = 0 latches no address, issues no pulse and ends with `pass` = 1.
- R11: During and right after reset, `prog_n` is 1, and `verify_sel`, `addr_latch`, `hv_en`, `vpp_en`, `busy`, `done` and `pass` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Starts a run when the block is idle or done |
| byte_cnt | input | ADDR_W+1 | Number of bytes to program, sampled at start |
| src_addr | output | ADDR_W | Address presented to the data source |
| src_data | input | DATA_W | Data source byte for `src_addr` |
| mem_addr | output | ADDR_W | Address driven to the memory |
| mem_data | output | DATA_W | Data byte driven to the memory |
| rd_data | input | DATA_W | Verify read-back from the memory |
| prog_n | output | 1 | Active-low program strobe |
| verify_sel | output | 1 | Mode select: 1 verify, 0 program |
| addr_latch | output | 1 | Address latch strobe; the rising edge latches `mem_addr` |
| hv_en | output | 1 | High-voltage mode enable level |
| vpp_en | output | 1 | Programming supply enable level |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished, results valid |
| pass | output | 1 | All bytes programmed and confirmed |
| fail_addr | output | ADDR_W | Address of the first failing byte |

## Verification
The assertions assume that `rd_data` settles within the verify gap after `addr_latch` rises or after a pulse ends. They also assume that `src_data` is a pure function of `src_addr` and that `byte_cnt` only matters at `start`. The bench models the memory with a per-byte count of pulses still needed. It changes `rd_data` only on a falling clock edge right after a pulse ends or a latch rises, well before the comparison at the end of the gap. The data source is a fixed arithmetic function of the address. `start` is only raised once `done` is high or the block is idle after reset.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HV_ON,
    S_VPP_ON,
    S_SELP,
    S_LATCH,
    S_DATA,
    S_PULSE,
    S_VERIFY,
    S_PREP,
    S_NEXT,
    S_VPP_OFF,
    S_FADDR,
    S_FLATCH,
    S_HV_OFF,
    S_DONE
  } seq_state_t;

endpackage

// File: rtl/otp_reset_sync.sv
module otp_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q_n = stage_q[1];

endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R1: a loaded count runs down one step per cycle without reloading itself
  assert_timer_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/otp_try_counter.sv
module otp_try_counter #(
  parameter int MAX_TRY = 25,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          at_max
);

  logic [CW-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (clr)      count_d = '0;
    else if (inc) count_d = count_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count  = count_q;
  assign at_max = (count_q == CW'(MAX_TRY));

  // R3: the attempt count never passes the cap
  assert_try_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(MAX_TRY));

  // R3: no further initial pulse is requested once the cap is reached
  assert_no_inc_at_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !at_max);

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 50000,
  parameter int GAP_CYC   = 4,
  parameter int MAX_TRY   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W:0]   byte_cnt,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic              prog_n,
  output logic              verify_sel,
  output logic              addr_latch,
  output logic              hv_en,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int TW = $clog2(3 * MAX_TRY * PULSE_CYC + 1);
  localparam int CW = $clog2(MAX_TRY + 1);
  localparam logic [TW-1:0] GAP_LD    = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] OVER_UNIT = TW'(3 * PULSE_CYC);

  logic rst_q_n;

  otp_reset_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W:0]   cnt_q;
  logic              over_q;
  logic              fail_seen_q;
  logic [ADDR_W-1:0] fail_addr_q;

  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              try_clr, try_inc, try_max;
  logic [CW-1:0]     tries;
  logic              addr_clr, addr_inc, data_cap, cnt_cap;
  logic              over_set, over_clr, fail_rec, fail_clr;
  logic              last_byte, cnt_zero;
  logic [TW-1:0]     over_len;

  otp_pulse_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  otp_try_counter #(.MAX_TRY(MAX_TRY), .CW(CW)) u_tries (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .clr    (try_clr),
    .inc    (try_inc),
    .count  (tries),
    .at_max (try_max)
  );

  assign last_byte = ((ADDR_W+1)'(addr_q) + (ADDR_W+1)'(1)) == cnt_q;
  assign cnt_zero  = (cnt_q == '0);
  assign over_len  = OVER_UNIT * TW'(tries) - TW'(1);

  // next-state and control
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = GAP_LD;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    data_cap = 1'b0;
    cnt_cap  = 1'b0;
    over_set = 1'b0;
    over_clr = 1'b0;
    fail_rec = 1'b0;
    fail_clr = 1'b0;
    case (state_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          state_d  = S_HV_ON;
          tmr_load = 1'b1;
          cnt_cap  = 1'b1;
          fail_clr = 1'b1;
          addr_clr = 1'b1;
        end
      end
      S_HV_ON: begin
        if (tmr_zero) begin
          state_d  = S_VPP_ON;
          tmr_load = 1'b1;
        end
      end
      S_VPP_ON: begin
        if (tmr_zero) begin
          state_d  = cnt_zero ? S_VPP_OFF : S_SELP;
          tmr_load = 1'b1;
          try_clr  = 1'b1;
        end
      end
      S_SELP: begin
        data_cap = 1'b1;
        if (tmr_zero) begin
          state_d  = S_LATCH;
          tmr_load = 1'b1;
        end
      end
      S_LATCH: begin
        if (tmr_zero) begin
          state_d  = S_DATA;
          tmr_load = 1'b1;
        end
      end
      S_DATA: begin
        if (tmr_zero) begin
          state_d  = S_PULSE;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LD;
          try_inc  = 1'b1;
          over_clr = 1'b1;
        end
      end
      S_PULSE: begin
        if (tmr_zero) begin
          state_d  = over_q ? S_NEXT : S_VERIFY;
          tmr_load = 1'b1;
        end
      end
      S_VERIFY: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (rd_data == data_q) begin
            over_set = 1'b1;
            state_d  = S_PREP;
          end else if (try_max) begin
            fail_rec = 1'b1;
            state_d  = S_NEXT;
          end else begin
            state_d  = S_PREP;
          end
        end
      end
      S_PREP: begin
        if (tmr_zero) begin
          state_d  = S_PULSE;
          tmr_load = 1'b1;
          if (over_q) begin
            tmr_val = over_len;
          end else begin
            tmr_val = PULSE_LD;
            try_inc = 1'b1;
          end
        end
      end
      S_NEXT: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          try_clr  = 1'b1;
          if (last_byte) begin
            state_d = S_VPP_OFF;
          end else begin
            addr_inc = 1'b1;
            state_d  = S_SELP;
          end
        end
      end
      S_VPP_OFF: begin
        if (tmr_zero) begin
          addr_clr = 1'b1;
          tmr_load = 1'b1;
          state_d  = cnt_zero ? S_HV_OFF : S_FADDR;
        end
      end
      S_FADDR: begin
        if (tmr_zero) begin
          state_d  = S_FLATCH;
          tmr_load = 1'b1;
        end
      end
      S_FLATCH: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (rd_data != src_data) fail_rec = 1'b1;
          if (last_byte) begin
            state_d = S_HV_OFF;
          end else begin
            addr_inc = 1'b1;
            state_d  = S_FADDR;
          end
        end
      end
      S_HV_OFF: begin
        if (tmr_zero) state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      cnt_q       <= '0;
      over_q      <= 1'b0;
      fail_seen_q <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (addr_clr)      addr_q <= '0;
      else if (addr_inc) addr_q <= addr_q + ADDR_W'(1);
      if (data_cap)      data_q <= src_data;
      if (cnt_cap)       cnt_q  <= byte_cnt;
      if (over_set)      over_q <= 1'b1;
      else if (over_clr) over_q <= 1'b0;
      if (fail_clr) begin
        fail_seen_q <= 1'b0;
        fail_addr_q <= '0;
      end else if (fail_rec && !fail_seen_q) begin
        fail_seen_q <= 1'b1;
        fail_addr_q <= addr_q;
      end
    end
  end

  // output decode
  assign src_addr   = addr_q;
  assign mem_addr   = addr_q;
  assign mem_data   = data_q;
  assign prog_n     = (state_q != S_PULSE);
  assign verify_sel = (state_q == S_VERIFY) || (state_q == S_FADDR) || (state_q == S_FLATCH);
  assign addr_latch = (state_q == S_LATCH) || (state_q == S_DATA) || (state_q == S_PULSE) ||
                      (state_q == S_VERIFY) || (state_q == S_PREP) || (state_q == S_FLATCH);
  assign hv_en      = (state_q != S_IDLE) && (state_q != S_HV_OFF) && (state_q != S_DONE);
  assign vpp_en     = (state_q == S_VPP_ON) || (state_q == S_SELP) || (state_q == S_LATCH) ||
                      (state_q == S_DATA) || (state_q == S_PULSE) || (state_q == S_VERIFY) ||
                      (state_q == S_PREP) || (state_q == S_NEXT);
  assign busy       = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done       = (state_q == S_DONE);
  assign pass       = done && !fail_seen_q;
  assign fail_addr  = fail_addr_q;

  // R7: the supply enable is nested inside the high-voltage mode enable
  assert_supply_nesting_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    vpp_en |-> hv_en);

  // R6, R8: a pulse only with the address latched, program mode and supply on
  assert_pulse_setup_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !prog_n |-> (addr_latch && !verify_sel && vpp_en));

  // R5: address held steady across a pulse
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!prog_n && !$past(prog_n)) |-> $stable(mem_addr));

  // R2: every initial pulse is followed by a verify cycle
  assert_verify_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($rose(prog_n) && !$past(over_q)) |-> verify_sel);

  // R9: results are only shown with the enables down and the run over
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |-> (!busy && !hv_en && prog_n));

endmodule

// File: tb/test_otp_prog_seq.sv
module test_otp_prog_seq;

  localparam int PC  = 4;
  localparam int GAP = 2;
  localparam int MT  = 25;

  // {cnt[4], k0[5], k1[5], k2[5], k3[5], fade[4], pass[1], fail_addr[8]}
  // k = initial pulses the byte needs (31 = never), fade = byte that reads wrong with supply off
  localparam logic [36:0] VEC [4] = '{
    {4'd3, 5'd1,  5'd2,  5'd3, 5'd0, 4'd15, 1'b1, 8'd0},
    {4'd4, 5'd1,  5'd25, 5'd31, 5'd2, 4'd15, 1'b0, 8'd2},
    {4'd2, 5'd4,  5'd1,  5'd0, 5'd0, 4'd1,  1'b0, 8'd1},
    {4'd4, 5'd31, 5'd1,  5'd1, 5'd1, 4'd3,  1'b0, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] byte_cnt = '0;
  logic [7:0] src_addr, src_data, mem_addr, mem_data, rd_data, fail_addr;
  logic       prog_n, verify_sel, addr_latch, hv_en, vpp_en, busy, done, pass;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  int kv [4];
  int pcount [4];
  int ocount [4];
  int fade = 15;
  int la = 0;
  int exp_p = 0;
  int exp_f = 0;
  int npulse = 0;
  int low_w = 0;
  bit verify_seen = 1'b0;
  logic prev_prog = 1'b1, prev_latch = 1'b0, prev_vpp = 1'b0, prev_hv = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] src_fn(input int a);
    return 8'(a * 59) ^ 8'hA5;
  endfunction

  assign src_data = src_fn(int'(src_addr));

  always_comb begin
    rd_data = src_fn(la) ^ 8'h01;
    if (la < 4) begin
      if (pcount[la] >= kv[la] && !(vpp_en == 1'b0 && la == fade)) rd_data = src_fn(la);
    end
  end

  otp_prog_seq #(
    .ADDR_W(8), .DATA_W(8), .PULSE_CYC(PC), .GAP_CYC(GAP), .MAX_TRY(MT)
  ) i_otp_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
    .src_addr(src_addr), .src_data(src_data), .mem_addr(mem_addr), .mem_data(mem_data),
    .rd_data(rd_data), .prog_n(prog_n), .verify_sel(verify_sel), .addr_latch(addr_latch),
    .hv_en(hv_en), .vpp_en(vpp_en), .busy(busy), .done(done), .pass(pass),
    .fail_addr(fail_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory model and live protocol checks
  always @(negedge clk) begin
    if (rst_n) begin
      if (verify_sel) verify_seen = 1'b1;
      if (prev_prog && !prog_n) begin
        npulse++;
        chk(addr_latch && !verify_sel && mem_data == src_fn(int'(mem_addr)), "R6 pulse setup",
            int'(mem_data), int'(src_fn(int'(mem_addr))));
        chk(vpp_en == 1'b1, "R8 pulse only with supply", int'(vpp_en), 1);
        if (la < 4 && pcount[la] > 0 && pcount[la] < kv[la] && pcount[la] < MT)
          chk(verify_seen, "R2 verify between pulses", int'(verify_seen), 1);
        verify_seen = 1'b0;
        low_w = 1;
      end else if (!prog_n) begin
        low_w++;
      end
      if (!prev_prog && prog_n && la < 4) begin
        if (pcount[la] < kv[la] && pcount[la] < MT) begin
          chk(low_w == PC, "R1 initial pulse width", low_w, PC);
          pcount[la]++;
        end else begin
          chk(low_w == 3 * pcount[la] * PC, "R4 overprogram width", low_w, 3 * pcount[la] * PC);
          ocount[la]++;
        end
      end
      if (!prev_latch && addr_latch) begin
        la = int'(mem_addr);
        if (vpp_en) begin
          chk(int'(mem_addr) == exp_p, "R5 program address order", int'(mem_addr), exp_p);
          exp_p++;
        end else begin
          chk(int'(mem_addr) == exp_f && verify_sel, "R8 final pass address order", int'(mem_addr), exp_f);
          exp_f++;
        end
      end
      if (!prev_vpp && vpp_en) chk(hv_en, "R7 mode enable before supply", int'(hv_en), 1);
      if (prev_hv && !hv_en)   chk(!vpp_en, "R7 supply off before mode", int'(vpp_en), 0);
    end
    prev_prog  = prog_n;
    prev_latch = addr_latch;
    prev_vpp   = vpp_en;
    prev_hv    = hv_en;
  end

  task automatic run(input logic [36:0] v);
    int cnt;
    int ep;
    int ef;
    int w;
    cnt = int'(v[36:33]);
    kv[0] = int'(v[32:28]);
    kv[1] = int'(v[27:23]);
    kv[2] = int'(v[22:18]);
    kv[3] = int'(v[17:13]);
    fade = int'(v[12:9]);
    ep = int'(v[8]);
    ef = int'(v[7:0]);
    for (int i = 0; i < 4; i++) begin
      pcount[i] = 0;
      ocount[i] = 0;
    end
    exp_p = 0;
    exp_f = 0;
    npulse = 0;
    @(negedge clk);
    byte_cnt = 9'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1 && !busy && !hv_en, "R9 done raised", int'(done), 1);
    chk(int'(pass) == ep, "R9 pass flag", int'(pass), ep);
    chk(int'(fail_addr) == ef, "R9 first failing address", int'(fail_addr), ef);
    for (int i = 0; i < cnt; i++) begin
      chk(pcount[i] == ((kv[i] > MT) ? MT : kv[i]), "R3 initial pulse count", pcount[i],
          (kv[i] > MT) ? MT : kv[i]);
      chk(ocount[i] == ((kv[i] <= MT) ? 1 : 0), "R3 R4 overprogram count", ocount[i],
          (kv[i] <= MT) ? 1 : 0);
    end
    chk(exp_p == cnt, "R5 bytes programmed", exp_p, cnt);
    chk(exp_f == cnt, "R8 bytes reread", exp_f, cnt);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R9 done held", int'(done), 1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      kv[i] = 0;
      pcount[i] = 0;
      ocount[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(prog_n && !verify_sel && !addr_latch && !hv_en && !vpp_en && !busy && !done && !pass,
        "R11 outputs in reset", int'({prog_n, hv_en, vpp_en, busy, done}), 16);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(prog_n && !verify_sel && !addr_latch && !hv_en && !vpp_en && !busy && !done && !pass,
        "R11 outputs after reset", int'({prog_n, hv_en, vpp_en, busy, done}), 16);

    for (int n = 0; n < 4; n++) run(VEC[n]);

    // R10: empty run
    run({4'd0, 5'd0, 5'd0, 5'd0, 5'd0, 4'd15, 1'b1, 8'd0});
    chk(npulse == 0, "R10 no pulse on empty run", npulse, 0);

    // rerun after failures: results cleared and recomputed
    run(VEC[0]);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule